// File: doc/BRIEF.md
# Change-Detect Interrupt Bank with Clear-on-Read Status

The block watches a set of input ports, eight ports of eight lines each by default. It keeps one sticky flag for every line. A flag is set whenever that line's level differs from its level one cycle earlier. Each port has its own status word. A read of a port returns the word and clears it in the same cycle. A read of one port has no effect on the words of the other ports. If a change arrives in the same cycle as the read that clears its word, it is kept for the next read, so no event is lost.

A line can be handed over to a PWM source. The line is then watched at the PWM level instead of the pin level, so each PWM edge raises the line's flag. A per-line mask selects which flags may drive the shared interrupt output. That output is high while any flag is set whose mask bit is 0. The pin levels arrive already synchronized, and the register bus protocol sits outside this block.

Top module: `chg_irq_bank`

## Requirements
- R1: During reset every status flag is 0, the read data is 0 and the interrupt output is 0.
- R2: A rising or a falling level on a line not assigned to PWM sets that line's flag at the first clock edge that samples the new level. Line k of port p is bit p*8+k of the flattened level, assign, PWM-level and mask buses.
- R3: A read (rd_en high with rd_port = p) returns port p's status word on rd_data from the next edge onwards. Bit k of rd_data is line k. rd_data holds its value while rd_en is low.
- R4: A flag stays set until its own port is read. Reads of other ports leave it unchanged.
- R5: A change sampled at the same edge as the read that clears its port stays latched. The read returns the old word and the next read returns the new flag.
- R6: irq is high exactly while some set flag has a mask bit of 0. A mask bit of 1 blocks its line from irq.
- R7: On a line whose assign bit is 1, the PWM level replaces the pin level, and pin changes on that line set no flag.
- R8: On an unmasked PWM-assigned line, every PWM edge sets the flag and raises irq again after the previous flag was cleared by a read.
- R9: The levels present when reset is released are taken as the baseline. No flag is set at the first edge after reset, even if the lines are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_lvl | input | NUM_PORTS*PORT_W | Synchronized pin levels, port-major |
| pwm_sel | input | NUM_PORTS*PORT_W | 1 = line follows the PWM level |
| pwm_lvl | input | NUM_PORTS*PORT_W | PWM level per line |
| mask | input | NUM_PORTS*PORT_W | 1 = line blocked from irq |
| rd_en | input | 1 | Status read strobe, one cycle per read |
| rd_port | input | IDX_W | Port index of the read |
| rd_data | output | PORT_W | Status word captured by the last read |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest case to reach is a line change landing in the exact cycle of the clearing read on the same port. The bench drives the pin edge and the read strobe in the same vector. It expects the old word back on that read and the new flag on the next one. A pin edge on a line handed to PWM is also hard to reach, and must stay invisible. For this, the vectors toggle the pin and the PWM level on that line in separate cycles with the line unmasked. Only the PWM edges may show up in the status word and on irq.

// File: rtl/cirq_pkg.sv
// Package for the change-detect interrupt bank.
// Holds the default geometry shared by the design and its checker.
package cirq_pkg;
    localparam int DEF_PORTS  = 8;
    localparam int DEF_PORT_W = 8;
endpackage

// File: rtl/cirq_edge_src.sv
// Per-port line source and change detector.
// Picks the PWM level or the pin level for each line and flags any
// difference from the previous cycle. Assumes the inputs are synchronous.
// Output is suppressed until armed is high (first cycle after reset).
module cirq_edge_src #(
    parameter int PORT_W = cirq_pkg::DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              armed,
    input  logic [PORT_W-1:0] pin,
    input  logic [PORT_W-1:0] psel,
    input  logic [PORT_W-1:0] plvl,
    output logic [PORT_W-1:0] evt
);
    logic [PORT_W-1:0] line;
    logic [PORT_W-1:0] line_q;

    // Per-line source choice between pin and PWM.
    always_comb begin
        line = (psel & plvl) | (~psel & pin);
    end

    // Keep last cycle's level; reload it during reset as the baseline.
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= line;
        else        line_q <= line;
    end

    // Report level differences once armed.
    always_comb begin
        evt = armed ? (line ^ line_q) : '0;
    end
endmodule

// File: rtl/cirq_status_word.sv
// Sticky status word of one port.
// Sets on change events and clears on a read of this port. A change that
// coincides with the clearing read wins, so no event is dropped.
module cirq_status_word #(
    parameter int PORT_W = cirq_pkg::DEF_PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PORT_W-1:0] evt,
    output logic [PORT_W-1:0] flags
);
    // Accumulate events; read clears the old content only.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~{PORT_W{clr}}) | evt;
    end
endmodule

// File: rtl/cirq_irq_reduce.sv
// Interrupt reduction: any flag whose mask bit is 0 raises irq.
// Purely combinational; assumes flags come from registers.
module cirq_irq_reduce #(
    parameter int WIDTH = cirq_pkg::DEF_PORTS * cirq_pkg::DEF_PORT_W
) (
    input  logic [WIDTH-1:0] flags,
    input  logic [WIDTH-1:0] mask,
    output logic             irq
);
    // OR of unmasked flags.
    always_comb begin
        irq = |(flags & ~mask);
    end
endmodule

// File: rtl/chg_irq_bank.sv
// Change-detect interrupt bank, top level.
// One change detector and one clear-on-read status word per port, a
// registered read port and a shared interrupt. Assumes the levels are
// already synchronized and the read strobe lasts one cycle per read.
module chg_irq_bank #(
    parameter int NUM_PORTS = cirq_pkg::DEF_PORTS,
    parameter int PORT_W    = cirq_pkg::DEF_PORT_W,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOTAL_W  = NUM_PORTS * PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TOTAL_W-1:0] pin_lvl,
    input  logic [TOTAL_W-1:0] pwm_sel,
    input  logic [TOTAL_W-1:0] pwm_lvl,
    input  logic [TOTAL_W-1:0] mask,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_port,
    output logic [PORT_W-1:0]  rd_data,
    output logic               irq
);
    logic               armed;
    logic [TOTAL_W-1:0] status_flat;
    logic [PORT_W-1:0]  sel_word;

    // Arm change detection one cycle after reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic [PORT_W-1:0] evt;
        logic              hit;

        // Read of this port.
        always_comb begin
            hit = rd_en && (rd_port == IDX_W'(p));
        end

        cirq_edge_src #(.PORT_W(PORT_W)) u_src (
            .clk   (clk),
            .rst_n (rst_n),
            .armed (armed),
            .pin   (pin_lvl[p*PORT_W +: PORT_W]),
            .psel  (pwm_sel[p*PORT_W +: PORT_W]),
            .plvl  (pwm_lvl[p*PORT_W +: PORT_W]),
            .evt   (evt)
        );

        cirq_status_word #(.PORT_W(PORT_W)) u_word (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (hit),
            .evt   (evt),
            .flags (status_flat[p*PORT_W +: PORT_W])
        );
    end

    // Select the addressed word; out-of-range index reads zero.
    always_comb begin
        sel_word = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (rd_port == IDX_W'(p)) sel_word = status_flat[p*PORT_W +: PORT_W];
        end
    end

    // Capture read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel_word;
    end

    cirq_irq_reduce #(.WIDTH(TOTAL_W)) u_irq (
        .flags (status_flat),
        .mask  (mask),
        .irq   (irq)
    );
endmodule

// File: rtl/cirq_checks.sv
// Checker for the change-detect interrupt bank, bound to the top.
// Relates ports and the status words over time.
module cirq_checks #(
    parameter int NUM_PORTS = cirq_pkg::DEF_PORTS,
    parameter int PORT_W    = cirq_pkg::DEF_PORT_W,
    localparam int IDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int TOTAL_W  = NUM_PORTS * PORT_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic [TOTAL_W-1:0] pin_lvl,
    input logic [TOTAL_W-1:0] pwm_sel,
    input logic [TOTAL_W-1:0] mask,
    input logic               rd_en,
    input logic [IDX_W-1:0]   rd_port,
    input logic [PORT_W-1:0]  rd_data,
    input logic               irq,
    input logic [TOTAL_W-1:0] status_flat
);
    logic [TOTAL_W-1:0] pin_d;
    logic [TOTAL_W-1:0] diff_q;
    logic               rst_d;
    logic               psel_d_zero;
    logic               gate_q;

    // Track last sampled pins and whether a plain-pin change window was open.
    always_ff @(posedge clk) begin
        pin_d       <= pin_lvl;
        rst_d       <= rst_n;
        psel_d_zero <= (pwm_sel == '0);
        diff_q      <= pin_lvl ^ pin_d;
        gate_q      <= rst_n && rst_d && (pwm_sel == '0) && psel_d_zero;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status_flat == '0 && rd_data == '0 && !irq));

    a_r2_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
        gate_q |-> ((status_flat & diff_q) == diff_q));

    a_r3_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && int'(rd_port) < NUM_PORTS)
        |=> rd_data == $past(status_flat[rd_port*PORT_W +: PORT_W]));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sticky
        a_r4_sticky_unread: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_en && rd_port == IDX_W'(p))
            |=> ((status_flat[p*PORT_W +: PORT_W] & $past(status_flat[p*PORT_W +: PORT_W]))
                 == $past(status_flat[p*PORT_W +: PORT_W])));
    end

    a_r6_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq);
endmodule

bind chg_irq_bank cirq_checks #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_lvl     (pin_lvl),
    .pwm_sel     (pwm_sel),
    .mask        (mask),
    .rd_en       (rd_en),
    .rd_port     (rd_port),
    .rd_data     (rd_data),
    .irq         (irq),
    .status_flat (status_flat)
);

// File: tb/test_chg_irq_bank.sv
// Bench for the change-detect interrupt bank: vector table then directed cases.
module test_chg_irq_bank;
    localparam int NP = 8;
    localparam int PW = 8;
    localparam int TW = NP * PW;
    localparam int NV = 15;

    typedef struct packed {
        logic [63:0] pin;
        logic [63:0] psel;
        logic [63:0] plvl;
        logic [63:0] msk;
        logic        rd;
        logic [2:0]  port;
        logic [7:0]  exp_data;
        logic        exp_irq;
    } vec_t;

    localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] M0   = 64'hFFFF_FFFF_FFFF_FFFE;
    localparam logic [63:0] M08  = 64'hFFFF_FFFF_FFFF_FEFE;

    localparam vec_t VECS [NV] = '{
        '{pin:64'h01,        psel:0,      plvl:0,      msk:ALL1, rd:0, port:0, exp_data:0,     exp_irq:0}, // R2 rise, R6 masked
        '{pin:64'h01,        psel:0,      plvl:0,      msk:M0,   rd:0, port:0, exp_data:0,     exp_irq:1}, // R6 unmask
        '{pin:64'h01,        psel:0,      plvl:0,      msk:M0,   rd:1, port:0, exp_data:8'h01, exp_irq:0}, // R3 read clears
        '{pin:64'h00,        psel:0,      plvl:0,      msk:M0,   rd:0, port:0, exp_data:0,     exp_irq:1}, // R2 fall
        '{pin:64'h2000_0000, psel:0,      plvl:0,      msk:M0,   rd:0, port:0, exp_data:0,     exp_irq:1}, // R2 port3
        '{pin:64'h2000_0000, psel:0,      plvl:0,      msk:M0,   rd:1, port:3, exp_data:8'h20, exp_irq:1}, // R4 other kept
        '{pin:64'h2000_0001, psel:0,      plvl:0,      msk:M0,   rd:1, port:0, exp_data:8'h01, exp_irq:1}, // R5 collide
        '{pin:64'h2000_0001, psel:0,      plvl:0,      msk:M0,   rd:1, port:0, exp_data:8'h01, exp_irq:0}, // R5 kept
        '{pin:64'h2000_0101, psel:64'h100,plvl:0,      msk:M08,  rd:0, port:0, exp_data:0,     exp_irq:0}, // R7 pin ignored
        '{pin:64'h2000_0001, psel:64'h100,plvl:64'h100,msk:M08,  rd:0, port:0, exp_data:0,     exp_irq:1}, // R8 pwm rise
        '{pin:64'h2000_0001, psel:64'h100,plvl:64'h100,msk:M08,  rd:1, port:1, exp_data:8'h01, exp_irq:0}, // R8 read
        '{pin:64'h2000_0001, psel:64'h100,plvl:0,      msk:M08,  rd:0, port:0, exp_data:0,     exp_irq:1}, // R8 pwm fall
        '{pin:64'h2000_0001, psel:64'h100,plvl:0,      msk:M08,  rd:1, port:1, exp_data:8'h01, exp_irq:0}, // R8 read
        '{pin:64'h2000_0000, psel:64'h100,plvl:0,      msk:ALL1, rd:0, port:0, exp_data:0,     exp_irq:0}, // R6 masked
        '{pin:64'h2000_0000, psel:64'h100,plvl:0,      msk:ALL1, rd:1, port:0, exp_data:8'h01, exp_irq:0}  // R3 read
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic [TW-1:0] pin_lvl, pwm_sel, pwm_lvl, mask;
    logic          rd_en;
    logic [2:0]    rd_port;
    logic [PW-1:0] rd_data;
    logic          irq;
    int            checks = 0;
    int            errors = 0;

    always #4 clk = ~clk;

    chg_irq_bank #(.NUM_PORTS(NP), .PORT_W(PW)) i_chg_irq_bank (
        .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .pwm_sel(pwm_sel),
        .pwm_lvl(pwm_lvl), .mask(mask), .rd_en(rd_en), .rd_port(rd_port),
        .rd_data(rd_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic drive(input logic [63:0] p, input logic [63:0] s, input logic [63:0] l,
                         input logic [63:0] m, input logic r, input logic [2:0] pt);
        @(negedge clk);
        pin_lvl = p; pwm_sel = s; pwm_lvl = l; mask = m; rd_en = r; rd_port = pt;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        pin_lvl = '0; pwm_sel = '0; pwm_lvl = '0; mask = '1; rd_en = 1'b0; rd_port = '0;
        tick(); tick();
        check("R1 irq", 32'(irq), 0);
        check("R1 rd_data", 32'(rd_data), 0);
        drive(0, 0, 0, ALL1, 0, 0);
        rst_n = 1'b1;
        tick(); tick();

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].pin, VECS[i].psel, VECS[i].plvl, VECS[i].msk, VECS[i].rd, VECS[i].port);
            tick();
            if (VECS[i].rd) check($sformatf("R3/R4/R5/R8 vec %0d data", i), 32'(rd_data), 32'(VECS[i].exp_data));
            check($sformatf("R2/R6/R7/R8 vec %0d irq", i), 32'(irq), 32'(VECS[i].exp_irq));
        end

        // R3: data holds while no read strobe.
        drive(64'h2000_0000, 0, 0, ALL1, 0, 0);
        tick();
        check("R3 hold", 32'(rd_data), 32'h01);

        // R9: lines high across reset release give no flag.
        drive(ALL1, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        tick();
        check("R1 irq in reset", 32'(irq), 0);
        drive(ALL1, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
        tick(); tick();
        check("R9 no irq", 32'(irq), 0);
        drive(ALL1, 0, 0, 0, 1, 5);
        tick();
        check("R9 port5 word", 32'(rd_data), 0);

        // R4: read port 2 must not clear a port 6 flag.
        drive(ALL1 & ~64'h0080_0000_0000_0000, 0, 0, 0, 0, 0);
        tick();
        check("R4 irq set", 32'(irq), 1);
        drive(ALL1 & ~64'h0080_0000_0000_0000, 0, 0, 0, 1, 2);
        tick();
        check("R4 port2 empty", 32'(rd_data), 0);
        check("R4 irq kept", 32'(irq), 1);
        drive(ALL1 & ~64'h0080_0000_0000_0000, 0, 0, 0, 1, 6);
        tick();
        check("R4 port6 word", 32'(rd_data), 32'h80);
        check("R4 irq cleared", 32'(irq), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule